// File: doc/BRIEF.md
# Standby Power Mode Controller

This block governs the operating mode of a dual-channel serial controller. It watches CPU writes to the two channel command registers, and it decodes two mode commands that may only arrive on channel A. One parks the device in a low-power standby state. The other brings it back to full operation. While the device is parked, every clock enable for the channel, timer and register logic is held low; only the oscillator domain keeps running. Clock gating is expressed as synchronous enable outputs.

The block also holds the small set of registers whose hardware-reset values it defines: two channel status registers, interrupt mask, interrupt status, output port, output port configuration and interrupt vector. In standby only three operations have any effect: reading the input port, writing the output port, and the wake command. Leaving standby takes a fixed, parameterised number of oscillator cycles, and a one-cycle ready pulse marks the moment the enables come back. Register contents (other than the output port) are not trusted across standby. Each one is flagged stale on read until software rewrites it. The interrupt output is held inactive for as long as the device is not running.

Top module: `power_mode_ctrl`

## Requirements
- R1: After hardware reset the block is running with every bit of clkEn at 1 and inStandby at 0. Status A (addr 0), status B (addr 1), mask (addr 4), interrupt status (addr 5), output port (addr 6) and port configuration (addr 7) read 0x00. The vector (addr 8) reads 0x0F, and rdStale is 0 for all of them.
- R2: A write to the channel A command address (addr 2) whose upper nibble is 0xC, made while running, sets inStandby and clears all of clkEn from the next cycle on.
- R3: While not running (standby or waking), writes to addresses 0, 1, 4, 5, 7, 8 are ignored. Reads of every address other than 9 return 0x00. A read of addr 9 returns inPort combinationally in every mode. A write to addr 6 updates outPort from the next cycle in every mode.
- R4: A channel A command with upper nibble 0xD, written in standby, keeps clkEn at 0 for exactly WAKE_CYC further cycles. clkEn is then restored, and wakeReady is high for exactly the first restored cycle.
- R5: Commands written to the channel B command address (addr 3) never change the mode. A repeated 0xC command in standby, a 0xD command while running, and any command while waking have no effect.
- R6: Asserting rstN (active low, asynchronous) returns the block to running with reset register values from standby or from waking.
- R7: Entering standby marks registers 0, 1, 4, 5, 7, 8 stale. A running read of a stale register sets rdStale until that register is written while running. The output port is never stale, and rdStale is 0 while not running.
- R8: irq is high only while running and only when some bit is set in both the interrupt status and the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, never gated |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrEn | input | 1 | CPU write strobe |
| rdEn | input | 1 | CPU read strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data / command byte |
| inPort | input | 8 | Parallel input port pins |
| rdData | output | 8 | Read data (combinational) |
| rdStale | output | 1 | Read register has not been rewritten since standby |
| outPort | output | 8 | Parallel output port register |
| clkEn | output | EN_W | Clock enables for channel, timer and register logic |
| inStandby | output | 1 | High in standby and during wake-up |
| wakeReady | output | 1 | One-cycle pulse when enables return |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest case to reach is the edge of the wake-up window. The restore has to land exactly WAKE_CYC cycles after the wake command, with the ready pulse in that cycle and not one earlier. Accesses made during the wait must still be blocked. The stimulus sends the wake command and then counts idle cycles while it tries blocked writes and stray commands. It also applies hardware reset in the middle of a wake-up. A pseudo-random phase mixes mode commands with register traffic so that stale-flag clearing and the interrupt mask are exercised around several standby round trips.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NSLOT  = 6;

  localparam logic [ADDR_W-1:0] A_SRA  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SRB  = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMDA = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMDB = 4'd3;
  localparam logic [ADDR_W-1:0] A_IMR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ISR  = 4'd5;
  localparam logic [ADDR_W-1:0] A_OPR  = 4'd6;
  localparam logic [ADDR_W-1:0] A_OPCR = 4'd7;
  localparam logic [ADDR_W-1:0] A_IVR  = 4'd8;
  localparam logic [ADDR_W-1:0] A_IPR  = 4'd9;

  localparam logic [3:0] CMD_SLEEP = 4'hC;
  localparam logic [3:0] CMD_WAKE  = 4'hD;
  localparam logic [DATA_W-1:0] VEC_RST = 8'h0F;

  localparam int S_IMR = 2;
  localparam int S_ISR = 3;
  localparam int S_IVR = 5;

  typedef enum logic [1:0] {MODE_RUN, MODE_SLEEP, MODE_WAKE} mode_e;

  typedef struct packed {
    logic running;
    logic regWr;
    logic portWr;
    logic invalidate;
  } ctlStb_t;

  function automatic logic [ADDR_W-1:0] slotAddr(input int s);
    case (s)
      0:       return A_SRA;
      1:       return A_SRB;
      2:       return A_IMR;
      3:       return A_ISR;
      4:       return A_OPCR;
      default: return A_IVR;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slotRst(input int s);
    return (s == S_IVR) ? VEC_RST : '0;
  endfunction

  function automatic logic isSlot(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int s = 0; s < NSLOT; s++) if (a == slotAddr(s)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int WAKE_CYC = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        cmdNib,
  output ctlStb_t           stb,
  output logic              inStandby,
  output logic              wakeReady
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  mode_e mode;
  logic [CNT_W-1:0] waitCnt;
  logic cmdAWr;

  assign cmdAWr = wrEn && (addr == A_CMDA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_RUN;
      waitCnt   <= '0;
      wakeReady <= 1'b0;
    end else begin
      wakeReady <= 1'b0;
      case (mode)
        MODE_RUN: begin
          if (cmdAWr && cmdNib == CMD_SLEEP) mode <= MODE_SLEEP;
        end
        MODE_SLEEP: begin
          if (cmdAWr && cmdNib == CMD_WAKE) begin
            mode    <= MODE_WAKE;
            waitCnt <= CNT_W'(WAKE_CYC - 1);
          end
        end
        default: begin
          if (waitCnt == '0) begin
            mode      <= MODE_RUN;
            wakeReady <= 1'b1;
          end else begin
            waitCnt <= waitCnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    stb.running    = (mode == MODE_RUN);
    stb.regWr      = stb.running && wrEn && isSlot(addr);
    stb.portWr     = wrEn && (addr == A_OPR);
    stb.invalidate = stb.running && cmdAWr && (cmdNib == CMD_SLEEP);
  end

  assign inStandby = !stb.running;
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] inPort,
  output logic [DATA_W-1:0] rdData,
  output logic              rdStale,
  output logic [DATA_W-1:0] outPort,
  output logic              irq
);
  logic [DATA_W-1:0] regQ [NSLOT];
  logic [NSLOT-1:0]  fresh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NSLOT; s++) regQ[s] <= slotRst(s);
      fresh <= '1;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (stb.regWr && addr == slotAddr(s)) begin
          regQ[s]  <= wrData;
          fresh[s] <= 1'b1;
        end else if (stb.invalidate) begin
          fresh[s] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           outPort <= '0;
    else if (stb.portWr) outPort <= wrData;
  end

  always_comb begin
    rdData  = '0;
    rdStale = 1'b0;
    if (rdEn) begin
      if (addr == A_IPR) begin
        rdData = inPort;
      end else if (stb.running) begin
        if (addr == A_OPR) rdData = outPort;
        for (int s = 0; s < NSLOT; s++) begin
          if (addr == slotAddr(s)) begin
            rdData  = regQ[s];
            rdStale = !fresh[s];
          end
        end
      end
    end
  end

  assign irq = stb.running && |(regQ[S_ISR] & regQ[S_IMR]);
endmodule

// File: rtl/power_mode_ctrl.sv
module power_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int WAKE_CYC = 20,
  parameter int EN_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] inPort,
  output logic [DATA_W-1:0] rdData,
  output logic              rdStale,
  output logic [DATA_W-1:0] outPort,
  output logic [EN_W-1:0]   clkEn,
  output logic              inStandby,
  output logic              wakeReady,
  output logic              irq
);
  ctlStb_t stb;

  pmc_ctrl #(.WAKE_CYC(WAKE_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .cmdNib(wrData[7:4]), .stb(stb), .inStandby(inStandby),
    .wakeReady(wakeReady)
  );

  pmc_regs i_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .inPort(inPort), .rdData(rdData),
    .rdStale(rdStale), .outPort(outPort), .irq(irq)
  );

  for (genvar g = 0; g < EN_W; g++) begin : g_en
    assign clkEn[g] = stb.running;
  end
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int EN_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [3:0]      addr,
  input logic [7:0]      wrData,
  input logic            rdStale,
  input logic [7:0]      outPort,
  input logic [EN_W-1:0] clkEn,
  input logic            inStandby,
  input logic            wakeReady,
  input logic            irq
);
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (!inStandby && wrEn && addr == 4'd2 && wrData[7:4] == 4'hC) |=> (inStandby && clkEn == '0)); // R2
  AST_PORT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'd6) |=> (outPort == $past(wrData))); // R3
  AST_READY_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    wakeReady |-> (!inStandby && $past(inStandby))); // R4
  AST_CMDB_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!inStandby && wrEn && addr == 4'd3) |=> !inStandby); // R5
  AST_NO_STALE_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    inStandby |-> !rdStale); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    inStandby |-> !irq); // R8
endmodule

bind power_mode_ctrl pmc_chk #(.EN_W(EN_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdStale(rdStale), .outPort(outPort), .clkEn(clkEn),
  .inStandby(inStandby), .wakeReady(wakeReady), .irq(irq)
);

// File: tb/test_power_mode_ctrl.sv
`timescale 1ns/1ps
module test_power_mode_ctrl;
  localparam int WAKE = 20;
  localparam int ENW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0, inPort = '0;
  logic [7:0] rdData, outPort;
  logic rdStale, inStandby, wakeReady, irq;
  logic [ENW-1:0] clkEn;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  power_mode_ctrl #(.WAKE_CYC(WAKE), .EN_W(ENW)) i_power_mode_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .inPort(inPort), .rdData(rdData), .rdStale(rdStale),
    .outPort(outPort), .clkEn(clkEn), .inStandby(inStandby),
    .wakeReady(wakeReady), .irq(irq)
  );

  // reference model: mode 0 running, 1 standby, 2 waking
  int mMode, mLeft;
  bit mRdy;
  logic [7:0] mReg [16];
  bit mOk [16];

  function automatic bit keptReg(input logic [3:0] a);
    return a == 0 || a == 1 || a == 4 || a == 5 || a == 7 || a == 8;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mLeft = 0; mRdy = 0;
      foreach (mReg[i]) begin mReg[i] = 8'h00; mOk[i] = 1; end
      mReg[8] = 8'h0F;
    end else begin
      mRdy = 0;
      if (wrEn && addr == 6) mReg[6] = wrData;
      if (mMode == 0 && wrEn && keptReg(addr)) begin
        mReg[addr] = wrData; mOk[addr] = 1;
      end
      if (mMode == 0) begin
        if (wrEn && addr == 2 && wrData[7:4] == 4'hC) begin
          mMode = 1;
          foreach (mOk[i]) if (keptReg(4'(i))) mOk[i] = 0;
        end
      end else if (mMode == 1) begin
        if (wrEn && addr == 2 && wrData[7:4] == 4'hD) begin mMode = 2; mLeft = WAKE; end
      end else begin
        mLeft--;
        if (mLeft == 0) begin mMode = 0; mRdy = 1; end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [7:0] eRd; bit eSt;
    eRd = 8'h00; eSt = 0;
    if (rdEn) begin
      if (addr == 9) eRd = inPort;
      else if (mMode == 0 && (addr == 6 || keptReg(addr))) begin
        eRd = mReg[addr]; eSt = keptReg(addr) && !mOk[addr];
      end
    end
    check("R2 clkEn", 32'(clkEn), (mMode == 0) ? 32'(7) : 32'(0));
    check("R2 inStandby", 32'(inStandby), 32'(mMode != 0));
    check("R4 wakeReady", 32'(wakeReady), 32'(mRdy));
    check("R8 irq", 32'(irq), 32'(mMode == 0 && |(mReg[5] & mReg[4])));
    check("R3 outPort", 32'(outPort), 32'(mReg[6]));
    check("R3 rdData", 32'(rdData), 32'(eRd));
    check("R7 rdStale", 32'(rdStale), 32'(eSt));
  endtask

  task automatic cyc(input bit we, input bit re, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = we; rdEn = re; addr = a; wrData = d;
    #1 compareAll();
  endtask

  task automatic idle(); cyc(0, 0, 0, 0); endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(input logic [3:0] a); cyc(0, 1, a, 0); endtask

  task automatic hwReset();
    @(negedge clk);
    wrEn = 0; rdEn = 0; rstN = 0;
    #1 compareAll();
    check("R6 reset inStandby", 32'(inStandby), 0);
    @(negedge clk); rstN = 1;
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    hwReset();
    // R1 reset values
    idle();
    check("R1 clkEn", 32'(clkEn), 32'(7));
    check("R1 inStandby", 32'(inStandby), 0);
    for (int a = 0; a < 9; a++) begin
      if (a == 2 || a == 3) continue;
      rd(4'(a));
      check("R1 reset value", 32'(rdData), (a == 8) ? 32'h0F : 32'h00);
      check("R1 reset fresh", 32'(rdStale), 0);
    end
    // R8 interrupt while running
    wr(4, 8'h0A); wr(5, 8'h02); idle();
    check("R8 irq raised", 32'(irq), 1);
    wr(0, 8'h11); wr(7, 8'h77); wr(8, 8'h40);
    // R5 channel B and stray wake
    wr(3, 8'hC0); idle();
    check("R5 cmdB sleep ignored", 32'(inStandby), 0);
    wr(2, 8'hD0); idle();
    check("R5 wake while running", 32'(inStandby), 0);
    // R2 enter standby
    wr(2, 8'hC5); idle();
    check("R2 standby entered", 32'(inStandby), 1);
    check("R2 enables off", 32'(clkEn), 0);
    check("R8 irq forced low", 32'(irq), 0);
    // R3 blocked accesses
    wr(4, 8'hFF); rd(4);
    check("R3 blocked read", 32'(rdData), 0);
    inPort = 8'hA5; rd(9);
    check("R3 input port", 32'(rdData), 32'hA5);
    wr(6, 8'h3C); idle();
    check("R3 output port write", 32'(outPort), 32'h3C);
    wr(2, 8'hC0); wr(3, 8'hD0); idle();
    check("R5 repeat sleep / cmdB wake", 32'(inStandby), 1);
    // R4 wake timing
    wr(2, 8'hD0);
    begin
      int n = 0;
      forever begin
        if (n == 0) wr(4, 8'hEE); else if (n == 3) wr(2, 8'hC0); else idle();
        if (clkEn != 0 || n > 100) break;
        n++;
      end
      check("R4 wake cycles", 32'(n), 32'(WAKE));
      check("R4 ready pulse", 32'(wakeReady), 1);
    end
    idle();
    check("R4 ready one cycle", 32'(wakeReady), 0);
    // R7 stale flags
    rd(4);
    check("R7 stale mask", 32'(rdStale), 1);
    check("R3 blocked write kept", 32'(rdData), 32'h0A);
    rd(6);
    check("R7 port never stale", 32'(rdStale), 0);
    wr(4, 8'h55); rd(4);
    check("R7 rewritten fresh", 32'(rdStale), 0);
    check("R7 rewritten value", 32'(rdData), 32'h55);
    // R6 reset from standby and from waking
    wr(2, 8'hC0); idle(); hwReset(); idle();
    check("R6 from standby", 32'(clkEn), 32'(7));
    rd(8);
    check("R6 vector value", 32'(rdData), 32'h0F);
    wr(2, 8'hC0); wr(2, 8'hD0); idle(); idle(); hwReset(); idle();
    check("R6 from waking", 32'(inStandby), 0);
    check("R6 port cleared", 32'(outPort), 0);
    // mixed traffic against the model
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      inPort = lfsr[15:8];
      if (lfsr[3:0] == 4'h1)      wr(2, 8'hC0);
      else if (lfsr[3:0] == 4'h2) wr(2, 8'hD3);
      else if (lfsr[3:0] == 4'h3) wr(3, {lfsr[4] ? 4'hC : 4'hD, 4'h0});
      else if (lfsr[2])           wr(4'(lfsr[7:4] % 10), lfsr[15:8]);
      else                        rd(4'(lfsr[7:4] % 10));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule